// File: doc/BRIEF.md
# Dual-Edge Maskable Interrupt Controller

This block gathers sixteen single-bit event sources, such as general purpose pins and a converter-done flag, and turns selected transitions on them into latched pending bits. Each source passes through a two-flop synchroniser. The synchronised value is then compared with its previous sample to find rising and falling transitions. Two independent enable words choose which transitions latch: one word for rising edges and one for falling edges. A source with both bits set latches on either edge. A source with neither bit set never latches.

Latched bits are held in a pending word and can be read back. Pending bits are cleared through a separate clear word with a two-step sequence: the host writes a mask, then writes zero. While a mask bit is held, the matching pending bit is forced to 0 and new edges on that source are dropped. One active-high request line tells the host that any bit is pending.

The host reaches the four words through a synchronous port. Writes take effect at the clock edge on which the write strobe is sampled. Read data is registered and appears one cycle after the read strobe.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the rising-enable, falling-enable, pending and clear words are all zero, `irq_o` is low, and `host_rdata` is zero.
- R2: The word select `host_addr` decodes as follows: 0 is the rising-enable word, 1 is the falling-enable word, 2 is the pending word and 3 is the clear word. A read strobe loads the selected word into `host_rdata` at the next clock edge, and `host_rdata` holds that value until the next read. The pending word is read-only, so a write to address 2 changes nothing.
- R3: Bit i of every word belongs to source `src_i[i]`. A 0-to-1 change of a source whose rising-enable bit is set sets its pending bit.
- R4: A 1-to-0 change of a source whose falling-enable bit is set sets its pending bit.
- R5: A source with both enable bits set latches on either transition. A source with neither enable bit set never latches.
- R6: Writing a mask to the clear word zeroes the masked pending bits at that write edge and leaves the other pending bits unchanged. Writing zero afterwards re-arms the sources without restoring any cleared bit.
- R7: While a clear-word bit is 1, the matching pending bit reads 0, and an edge on that source whose latching edge comes before the edge that writes the bit back to 0 is lost.
- R8: An edge whose latching edge coincides with the write that returns its clear bit to 0 is latched.
- R9: Writing all ones to the clear word and then zero leaves every pending bit at zero.
- R10: `irq_o` is high exactly when at least one pending bit is set, and it changes at the same clock edge as the pending word.
- R11: A source change applied before clock edge k sets its pending bit, and `irq_o` if the word was empty, at edge k+2: two synchroniser flops and then the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | 16 | Event sources, asynchronous to `clk` |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 2 | Word select |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Combined request, active high |

## Verification
The properties assume that reset is held across at least one clock edge, so that the first post-reset `$past` values are the reset contents. They also assume that the host never asserts read and write in the same cycle. The stimulus holds reset for three edges and drives the strobes, address, data and sources only on falling clock edges, one operation at a time. Each source is left stable for at least four cycles between changes. The only exception is the two deliberate races, where a source edge is aligned to the edge that writes zero to the clear word, or lands one cycle before it.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RISE_EN = 2'd0,
    SEL_FALL_EN = 2'd1,
    SEL_PENDING = 2'd2,
    SEL_CLEAR   = 2'd3
  } word_sel_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eic_edge.sv
module eic_edge #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  always_comb begin
    rise = level & ~prev_q;
    fall = ~level & prev_q;
  end
endmodule

// File: rtl/eic_cfg.sv
module eic_cfg
  import eic_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rise_en_q,
  output logic [WIDTH-1:0]  fall_en_q,
  output logic [WIDTH-1:0]  clr_q,
  output logic [WIDTH-1:0]  clr_d
);
  logic             rise_ce, fall_ce, clr_ce;
  logic [WIDTH-1:0] rise_d, fall_d;

  always_comb begin
    rise_ce = wr && (word_sel_e'(addr) == SEL_RISE_EN);
    fall_ce = wr && (word_sel_e'(addr) == SEL_FALL_EN);
    clr_ce  = wr && (word_sel_e'(addr) == SEL_CLEAR);
    rise_d  = rise_ce ? wdata : rise_en_q;
    fall_d  = fall_ce ? wdata : fall_en_q;
    clr_d   = clr_ce  ? wdata : clr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      clr_q     <= '0;
    end else begin
      rise_en_q <= rise_d;
      fall_en_q <= fall_d;
      clr_q     <= clr_d;
    end
  end
endmodule

// File: rtl/eic_latch.sv
module eic_latch #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise,
  input  logic [WIDTH-1:0] fall,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] clr_next,
  output logic [WIDTH-1:0] pend_q,
  output logic             any_q
);
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] pend_d;

  // The mask applied is the clear word as it will stand after this edge,
  // so an edge coinciding with the write of zero is kept.
  always_comb begin
    hit    = (rise & rise_en) | (fall & fall_en);
    pend_d = (pend_q | hit) & ~clr_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      any_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      any_q  <= |pend_d;
    end
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [1:0]         host_addr,
  input  logic [NUM_SRC-1:0] host_wdata,
  output logic [NUM_SRC-1:0] host_rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] src_s, rise, fall;
  logic [NUM_SRC-1:0] rise_en_q, fall_en_q, clr_q, clr_d;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] rdata_d, rdata_q;

  eic_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_i), .q(src_s));

  eic_edge #(.WIDTH(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(src_s), .rise(rise), .fall(fall));

  eic_cfg #(.WIDTH(NUM_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .rise_en_q(rise_en_q), .fall_en_q(fall_en_q),
    .clr_q(clr_q), .clr_d(clr_d));

  eic_latch #(.WIDTH(NUM_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .rise_en(rise_en_q), .fall_en(fall_en_q), .clr_next(clr_d),
    .pend_q(status_q), .any_q(irq_o));

  always_comb begin
    rdata_d = rdata_q;
    if (host_rd) begin
      unique case (word_sel_e'(host_addr))
        SEL_RISE_EN: rdata_d = rise_en_q;
        SEL_FALL_EN: rdata_d = fall_en_q;
        SEL_PENDING: rdata_d = status_q;
        SEL_CLEAR:   rdata_d = clr_q;
        default:     rdata_d = rdata_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] clr,
  input logic [NUM_SRC-1:0] ren,
  input logic [NUM_SRC-1:0] fen,
  input logic               irq
);
  // R7
  clr_hides_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & clr) == '0);

  // R10
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status != '0));

  // R5
  new_bit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(ren | fen)) == '0);

  // R6
  drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status) & ~clr) == '0);
endmodule

bind edge_irq_ctrl eic_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status_q), .clr(clr_q),
  .ren(rise_en_q), .fen(fall_en_q), .irq(irq_o));

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_i = '0;
  logic         host_wr = 1'b0;
  logic         host_rd = 1'b0;
  logic [1:0]   host_addr = '0;
  logic [N-1:0] host_wdata = '0;
  logic [N-1:0] host_rdata;
  logic         irq_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [N-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .host_wr(host_wr),
    .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_o(irq_o));

  task automatic check(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Monitor: pops one expected item for every read the design serves.
  initial begin
    forever begin
      @(posedge clk);
      if (host_rd === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", host_rdata, '0);
        else begin
          logic [N-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(host_rdata === e, t, host_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [N-1:0] e, input string t);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic drive_src(input logic [N-1:0] v);
    @(negedge clk);
    src_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic irq_is(input logic e, input string t);
    check(irq_o === e, t, {15'd0, irq_o}, {15'd0, e});
  endtask

  // Source edge raced against the write of zero to the clear word.
  task automatic race(input logic [N-1:0] v, input int gap);
    @(negedge clk);
    src_i = v;
    repeat (gap) @(negedge clk);
    host_wr = 1'b1; host_addr = 2'd3; host_wdata = '0;
    @(negedge clk);
    host_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    irq_is(1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    check(host_rdata === '0, "R1 rdata after reset", host_rdata, '0);
    rd(2'd0, 16'h0000, "R1 rise enable reset");
    rd(2'd1, 16'h0000, "R1 fall enable reset");
    rd(2'd2, 16'h0000, "R1 pending reset");
    rd(2'd3, 16'h0000, "R1 clear reset");

    wr(2'd0, 16'h00F0);
    wr(2'd1, 16'h0F00);
    rd(2'd0, 16'h00F0, "R2 rise enable readback");
    rd(2'd1, 16'h0F00, "R2 fall enable readback");
    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'h0000, "R2 pending write ignored");

    // R11 latency: src applied before edge k, pending at edge k+2
    @(negedge clk);
    src_i = 16'h0010;
    @(negedge clk); irq_is(1'b0, "R11 after first sync edge");
    @(negedge clk); irq_is(1'b0, "R11 after second sync edge");
    @(negedge clk); irq_is(1'b1, "R11 latched at third edge");
    rd(2'd2, 16'h0010, "R11 pending bit 4");

    drive_src(16'h00FF);
    rd(2'd2, 16'h00F0, "R3 rising latched, R5 unenabled ignored");
    irq_is(1'b1, "R10 irq with pending");
    drive_src(16'h0FFF);
    rd(2'd2, 16'h00F0, "R3 rise without enable ignored");
    drive_src(16'h00FF);
    rd(2'd2, 16'h0FF0, "R4 falling latched");

    wr(2'd3, 16'h00F0);
    rd(2'd2, 16'h0F00, "R6 masked bits cleared");
    rd(2'd3, 16'h00F0, "R2 clear readback");
    wr(2'd3, 16'h0000);
    rd(2'd2, 16'h0F00, "R6 zero write keeps others");

    wr(2'd0, 16'h80F0);
    wr(2'd1, 16'h8F00);
    drive_src(16'h80FF);
    rd(2'd2, 16'h8F00, "R5 both-edge source on rise");
    wr(2'd3, 16'h8000);
    wr(2'd3, 16'h0000);
    rd(2'd2, 16'h0F00, "R6 bit 15 cleared");
    drive_src(16'h00FF);
    rd(2'd2, 16'h8F00, "R5 both-edge source on fall");

    wr(2'd3, 16'h0010);
    drive_src(16'h00EF);
    drive_src(16'h00FF);
    rd(2'd2, 16'h8F00, "R7 edge dropped while clear held");
    wr(2'd3, 16'h0000);
    rd(2'd2, 16'h8F00, "R7 dropped edge not replayed");

    wr(2'd3, 16'h0020);
    drive_src(16'h00DF);
    race(16'h00FF, 2);
    rd(2'd2, 16'h8F20, "R8 edge on release latched");

    wr(2'd3, 16'h0040);
    drive_src(16'h00BF);
    race(16'h00FF, 3);
    rd(2'd2, 16'h8F20, "R7 edge one cycle before release lost");

    wr(2'd2, 16'h0000);
    rd(2'd2, 16'h8F20, "R2 pending write of zero ignored");

    wr(2'd3, 16'hFFFF);
    rd(2'd2, 16'h0000, "R9 all cleared");
    irq_is(1'b0, "R9 R10 irq low after clear all");
    wr(2'd3, 16'h0000);
    rd(2'd2, 16'h0000, "R9 stays clear after zero");
    irq_is(1'b0, "R10 irq low with empty word");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(1'b0, "scoreboard drain", '0, '0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule